// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog timer. Its timeout counter advances on a strobe from a dedicated 1 MHz time base, not on every cycle of the register clock. Software selects one of eight timeout periods and enables the watchdog through a small 8-bit control register. It must pulse the kick input before the selected period runs out. If no kick arrives in time, the block raises a one-cycle system reset pulse and starts counting again.

Turning the watchdog on takes one plain write. Turning it off is guarded. A write that sets both the unlock bit and the enable bit opens a window of four register-clock cycles. Only inside that window does a write with the enable bit at zero take effect.

A static strict-mode input extends the same guard to the period select. With strict mode on, a new select value is accepted only while the window is open.

The base period is a parameter. At its default of 16384 ticks, the periods run from 16384 ticks (about 16 ms) up to 2097152 ticks (about 2 s).

Top module: `wdt_guard`

## Requirements
- R1: After reset, rd_data reads 0x00 and sys_rst is low.
- R2: rd_data reads {3'b000, unlock, enable, select[2:0]}, with unlock in bit 4, enable in bit 3 and select in bits 2..0. Bits 7..5 always read zero, and whatever is written to them is ignored.
- R3: While enabled, sys_rst goes high exactly BASE_TICKS<<select ticks after the last counter restart. The pulse appears in the cycle after the edge that ends the period.
- R4: sys_rst is high for one cycle only. The expiry itself restarts the count, so the pulses repeat with the same period for as long as no kick arrives.
- R5: Pulsing kick for one cycle restarts the count from zero.
- R6: A write that changes the select restarts the count. A write that leaves the select unchanged does not restart it.
- R7: The count advances only in cycles where tick is high.
- R8: Writing enable (bit 3) as one always enables the watchdog, with no unlock needed. Writing it as zero while unlock reads zero leaves the watchdog enabled.
- R9: A write with bit 4 set makes unlock read one for the next four cycles, after which it clears by itself. Writing bit 4 as zero does not clear it early.
- R10: A write with bit 3 at zero, made while unlock reads one, disables the watchdog. The same write made one cycle after the window has closed leaves the watchdog enabled.
- R11: While disabled, sys_rst never rises and the count stays at zero.
- R12: When strict is high, a write changes the select only if unlock already reads one before that write. Otherwise the select is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe, one per timeout tick |
| kick | input | 1 | Restart the timeout count |
| strict | input | 1 | Also guard select changes with the unlock window |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| sys_rst | output | 1 | One-cycle system reset pulse on timeout |

## Verification
The bench aims at the edges of the unlock window.

- A disabling write on the fourth cycle must take effect, and the same write on the fifth must not. A window that is one cycle short or one cycle long therefore fails one of the two checks.
- The bench measures the timeout distance exactly after an enable, after a kick, and after a select change that happens mid-count. A design that skips the restart on a select change either fires too early or misses the compare entirely.
- With strict mode on, the bench checks that a single write which sets the unlock bit and a new select together cannot change the select. A design that samples the unlock bit after the write would let that write through.
- A pulse longer than one cycle, a count that runs while tick is low, or a reset raised while disabled each show up at sys_rst.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int BASE_TICKS = 16384,
  parameter int CE_WINDOW  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       strict,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_rst
);
  localparam int CW  = $clog2(BASE_TICKS) + 8;
  localparam int CEW = $clog2(CE_WINDOW + 1);
  localparam logic [CW-1:0] BASE_W = CW'(BASE_TICKS);

  logic           en_q;
  logic [2:0]     sel_q;
  logic [CEW-1:0] ce_cnt;
  logic [CW-1:0]  cnt;
  logic           rst_q;

  logic           unlocked, en_d, restart, expire;
  logic [2:0]     sel_d;
  logic [CW-1:0]  lim;

  assign unlocked = ce_cnt != '0;
  assign en_d     = wr_en ? (wr_data[3] | (en_q & ~unlocked)) : en_q;
  assign sel_d    = (wr_en && (!strict || unlocked)) ? wr_data[2:0] : sel_q;
  assign restart  = kick | (en_d & ~en_q) | (sel_d != sel_q);
  assign lim      = BASE_W << sel_q;
  assign expire   = en_q & tick & ~restart & (cnt == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ce_cnt <= '0;
    else if (wr_en && wr_data[4])
      ce_cnt <= CEW'(CE_WINDOW);
    else if (unlocked)
      ce_cnt <= ce_cnt - CEW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q || restart || expire)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= expire;
  end

  assign sys_rst = rst_q;
  assign rd_data = {3'b000, unlocked, en_q, sel_q};
endmodule

module wdt_guard_chk #(
  parameter int CE_WINDOW = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       kick,
  input logic       strict,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sys_rst
);
  logic [7:0] ce_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                   ce_run <= '0;
    else if (wr_en && wr_data[4]) ce_run <= '0;
    else if (rd_data[4])          ce_run <= ce_run + 8'd1;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  assert_kick_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !sys_rst);

  assert_guarded_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[3]) |-> $past(rd_data[4] && wr_en && !wr_data[3]));

  assert_ce_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> (ce_run < 8'(CE_WINDOW)));

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(rd_data[3]));

  assert_strict_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:0] != $past(rd_data[2:0])) |-> $past(!strict || rd_data[4]));
endmodule

bind wdt_guard wdt_guard_chk i_chk (.*);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       kick = 1'b0;
  logic       strict = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sys_rst;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wdt_guard #(.BASE_TICKS(4)) i_wdt_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .strict(strict),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sys_rst(sys_rst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!sys_rst && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!sys_rst) n = -1;
  endtask

  task automatic quiet(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sys_rst) seen++;
    end
  endtask

  task automatic t_reset();
    chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
    chk(sys_rst == 1'b0, "R1 reset sys_rst", sys_rst, 0);
  endtask

  task automatic t_timeout();
    int n;
    wr(8'h08); measure(n); chk(n == 4, "R3 period sel0", n, 4);
    wr(8'h0B); measure(n); chk(n == 32, "R3 period sel3", n, 32);
    wr(8'h0D); measure(n); chk(n == 128, "R3 period sel5", n, 128);
  endtask

  task automatic t_pulse();
    int n;
    @(negedge clk);
    chk(sys_rst == 1'b0, "R4 pulse one cycle", sys_rst, 0);
    measure(n); chk(n == 127, "R4 repeat period", n, 127);
  endtask

  task automatic t_kick();
    int n, seen;
    wr(8'h0A);
    quiet(10, seen); chk(seen == 0, "R5 no early pulse", seen, 0);
    do_kick(); measure(n); chk(n == 16, "R5 kick restart", n, 16);
  endtask

  task automatic t_select();
    int n, seen;
    wr(8'h0B);
    quiet(20, seen);
    wr(8'h0A); measure(n); chk(n == 16, "R6 select change restarts", n, 16);
    quiet(6, seen);
    wr(8'h0A); measure(n); chk(n == 9, "R6 same select keeps count", n, 9);
  endtask

  task automatic t_tick();
    int n, seen;
    tick = 1'b0;
    wr(8'h08);
    quiet(20, seen); chk(seen == 0, "R7 no tick no count", seen, 0);
    tick = 1'b1;
    measure(n); chk(n == 4, "R7 count resumes", n, 4);
  endtask

  task automatic t_lock();
    wr(8'h00);
    chk(rd_data == 8'h08, "R8 locked disable ignored", rd_data, 8'h08);
  endtask

  task automatic t_unlock();
    int seen;
    wr(8'h1F);
    chk(rd_data == 8'h1F, "R9 unlock visible", rd_data, 8'h1F);
    repeat (3) @(negedge clk);
    chk(rd_data[4] == 1'b1, "R9 unlock on 4th cycle", rd_data[4], 1);
    wr(8'h07);
    chk(rd_data == 8'h07, "R10 disable in window", rd_data, 8'h07);
    quiet(700, seen); chk(seen == 0, "R11 no reset while off", seen, 0);
    wr(8'h1F);
    repeat (4) @(negedge clk);
    chk(rd_data[4] == 1'b0, "R9 unlock self-clears", rd_data[4], 0);
    wr(8'h07);
    chk(rd_data == 8'h0F, "R10 late disable ignored", rd_data, 8'h0F);
    wr(8'h18);
    wr(8'h08);
    chk(rd_data[4] == 1'b1, "R9 zero write keeps unlock", rd_data[4], 1);
    chk(rd_data[3] == 1'b1, "R8 enable needs no unlock", rd_data[3], 1);
  endtask

  task automatic t_strict();
    strict = 1'b1;
    repeat (5) @(negedge clk);
    wr(8'h0B);
    chk(rd_data == 8'h08, "R12 select locked", rd_data, 8'h08);
    wr(8'h1F);
    chk(rd_data == 8'h18, "R12 same-write unlock ignored", rd_data, 8'h18);
    wr(8'h0B);
    chk(rd_data == 8'h1B, "R12 select in window", rd_data, 8'h1B);
    strict = 1'b0;
  endtask

  task automatic t_reserved();
    repeat (5) @(negedge clk);
    wr(8'hE9);
    chk(rd_data == 8'h09, "R2 reserved bits read zero", rd_data, 8'h09);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timeout();
    t_pulse();
    t_kick();
    t_select();
    t_tick();
    t_lock();
    t_unlock();
    t_strict();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule